// File: doc/BRIEF.md
# Bidirectional Split Row-Scan Shift Register

This block is the row scanner used when a column/row panel driver works as the common (row) side. It holds one bit per row output in a 160-stage register that advances by one position each time the line strobe falls. The register either runs as a single 160-stage chain, or splits into two 80-stage chains that advance together, each with its own serial input. A direction input sets which end each chain is loaded from.

The direction input also decides which of the two end pins is an input and which is an output. The end pin at the loading end takes serial data in. The end pin at the far end gives the cascade bit to the next device in the chain. Each end pin is modelled as a separate input, output and output-enable. In split mode, the serial input for the upper half comes from a separate data input. The register image is available on a 160-bit output. Bit 0 is row 1 and bit 159 is row 160.

Top module: `bidir_scan_shreg`

## Requirements
- R1: The register moves by exactly one position at each clock edge where `lp_i` is sampled low and was sampled high at the previous edge. At all other edges it holds its value, including while `lp_i` stays high, stays low, or rises.
- R2: With `dual_i`=0 and `dir_i`=1, a shift loads `end1_i` into `row_o[0]` and moves every `row_o[k]` to `row_o[k+1]`.
- R3: With `dual_i`=0 and `dir_i`=0, a shift loads `end2_i` into `row_o[159]` and moves every `row_o[k]` to `row_o[k-1]`.
- R4: With `dual_i`=1 and `dir_i`=1, a shift loads `end1_i` into `row_o[0]` and `d7_i` into `row_o[80]`. The other bits move upward. `row_o[79]` is dropped and does not pass into `row_o[80]`.
- R5: With `dual_i`=1 and `dir_i`=0, a shift loads `end2_i` into `row_o[159]` and `d7_i` into `row_o[79]`. The other bits move downward. `row_o[80]` does not pass into `row_o[79]`.
- R6: With `dual_i`=0, `d7_i` has no effect. The two halves form one chain, so `row_o[79]` passes into `row_o[80]` (direction 1) and `row_o[80]` passes into `row_o[79]` (direction 0).
- R7: `end2_oe_o` equals `dir_i` and `end1_oe_o` equals its inverse. The end pin that is not enabled has its output at 0.
- R8: The enabled end output carries the current content of the last stage, which is the bit the next shift pushes out. That is `row_o[159]` on `end2_o` when `dir_i`=1, and `row_o[0]` on `end1_o` when `dir_i`=0.
- R9: While `rst_ni` is low, all 160 stages are 0 and the strobe history is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_i | input | 1 | Line strobe; a sampled falling edge shifts the register |
| dual_i | input | 1 | 1: two 80-stage chains, 0: one 160-stage chain |
| dir_i | input | 1 | 1: shift toward row 160, 0: shift toward row 1 |
| end1_i | input | 1 | Serial input at the row-1 end |
| end1_o | output | 1 | Cascade output at the row-1 end |
| end1_oe_o | output | 1 | Output enable of the row-1 end pin |
| end2_i | input | 1 | Serial input at the row-160 end |
| end2_o | output | 1 | Cascade output at the row-160 end |
| end2_oe_o | output | 1 | Output enable of the row-160 end pin |
| d7_i | input | 1 | Serial input of the upper half in split mode |
| row_o | output | 160 | Register image, bit 0 = row 1 |

## Verification
The embedded assertions check the following on every cycle:
- the register holds at any edge that is not a shift;
- two shifts are never back to back;
- the loading stage of each half takes its serial input;
- the split and joined behaviour at the boundary between the halves is correct.

Some behaviour depends on long histories and needs the bench's scenarios. This includes:
- full traversals of 160 and 80 stages in all four direction and mode combinations;
- the cascade bit leaving the far end;
- `d7_i` toggling in single mode without effect;
- changes of direction while the register holds data;
- a reset in the middle of a run.

A behavioural reference model checks all of these on every clock.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    SCAN_SINGLE_UP = 2'b00,
    SCAN_SINGLE_DN = 2'b01,
    SCAN_DUAL_UP   = 2'b10,
    SCAN_DUAL_DN   = 2'b11
  } scan_mode_e;

  function automatic scan_mode_e scan_mode(input logic dual, input logic up);
    case ({dual, up})
      2'b01:   return SCAN_SINGLE_UP;
      2'b00:   return SCAN_SINGLE_DN;
      2'b11:   return SCAN_DUAL_UP;
      default: return SCAN_DUAL_DN;
    endcase
  endfunction

endpackage

// File: rtl/lp_fall_det.sv
module lp_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_i,
  output logic fall_o
);

  logic lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_i;
  end

  assign fall_o = lp_q & ~lp_i;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R1

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int W = 80
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         up_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (shift_i) q <= up_i ? {q[W-2:0], sin_i} : {sin_i, q[W-1:1]};
  end

  assign q_o = q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(q_o)); // R1
  AST_ENTRY_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && up_i |=> q_o[0] == $past(sin_i)); // R2
  AST_ENTRY_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !up_i |=> q_o[W-1] == $past(sin_i)); // R3

endmodule

// File: rtl/bidir_scan_shreg.sv
module bidir_scan_shreg
  import scan_pkg::*;
#(
  parameter int ROWS = 160
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lp_i,
  input  logic            dual_i,
  input  logic            dir_i,
  input  logic            end1_i,
  output logic            end1_o,
  output logic            end1_oe_o,
  input  logic            end2_i,
  output logic            end2_o,
  output logic            end2_oe_o,
  input  logic            d7_i,
  output logic [ROWS-1:0] row_o
);

  localparam int HALF = ROWS / 2;

  logic            shift;
  scan_mode_e      mode;
  logic [1:0]      half_sin;
  logic [HALF-1:0] half_q [2];

  lp_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lp_i   (lp_i),
    .fall_o (shift)
  );

  assign mode = scan_mode(dual_i, dir_i);

  // index 0 = rows 1..HALF, index 1 = rows HALF+1..ROWS
  always_comb begin
    case (mode)
      SCAN_SINGLE_UP: half_sin = {half_q[0][HALF-1], end1_i};
      SCAN_SINGLE_DN: half_sin = {end2_i, half_q[1][0]};
      SCAN_DUAL_UP:   half_sin = {d7_i, end1_i};
      default:        half_sin = {end2_i, d7_i};
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_half
    scan_chain #(.W(HALF)) u_chain (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (shift),
      .up_i    (dir_i),
      .sin_i   (half_sin[g]),
      .q_o     (half_q[g])
    );
  end

  assign row_o     = {half_q[1], half_q[0]};
  assign end2_oe_o = dir_i;
  assign end1_oe_o = ~dir_i;
  assign end2_o    = dir_i & row_o[ROWS-1];
  assign end1_o    = ~dir_i & row_o[0];

  AST_DUAL_SPLIT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift && dual_i && dir_i |=> row_o[HALF] == $past(d7_i)); // R4
  AST_DUAL_SPLIT_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift && dual_i && !dir_i |=> row_o[HALF-1] == $past(d7_i)); // R5
  AST_SINGLE_JOIN_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift && !dual_i && dir_i |=> row_o[HALF] == $past(row_o[HALF-1])); // R6
  AST_SINGLE_JOIN_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift && !dual_i && !dir_i |=> row_o[HALF-1] == $past(row_o[HALF])); // R6

endmodule

// File: tb/sim_bidir_scan_shreg.sv
module sim_bidir_scan_shreg;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         lp = 1'b0, dual = 1'b0, dir = 1'b1;
  logic         e1 = 1'b0, e2 = 1'b0, d7 = 1'b0;
  logic         e1_o, e1_oe, e2_o, e2_oe;
  logic [159:0] row;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R9";
  logic [15:0] lf = 16'hACE1;

  bidir_scan_shreg u0 (
    .clk_i(clk), .rst_ni(rst_n), .lp_i(lp), .dual_i(dual), .dir_i(dir),
    .end1_i(e1), .end1_o(e1_o), .end1_oe_o(e1_oe),
    .end2_i(e2), .end2_o(e2_o), .end2_oe_o(e2_oe),
    .d7_i(d7), .row_o(row)
  );

  // behavioural reference, indexed by row number 1..160
  logic m [1:160];
  logic lp_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int y = 1; y <= 160; y++) m[y] = 1'b0;
      lp_prev = 1'b0;
    end else begin
      if (lp_prev && !lp) begin
        if (dir) begin
          for (int y = 160; y >= 2; y--)
            if (!(dual && y == 81)) m[y] = m[y-1];
          m[1] = e1;
          if (dual) m[81] = d7;
        end else begin
          for (int y = 1; y <= 159; y++)
            if (!(dual && y == 80)) m[y] = m[y+1];
          m[160] = e2;
          if (dual) m[80] = d7;
        end
      end
      lp_prev = lp;
    end
  end

  task automatic chk(input string req, input string what, input logic [159:0] act,
                     input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [159:0] exp_row;
    for (int y = 1; y <= 160; y++) exp_row[y-1] = m[y];
    chk(cur_req, "row", row, exp_row);
    chk("R7", "end2_oe", {159'd0, e2_oe}, {159'd0, dir});
    chk("R7", "end1_oe", {159'd0, e1_oe}, {159'd0, !dir});
    chk("R8", "end2_o", {159'd0, e2_o}, {159'd0, dir ? m[160] : 1'b0});
    chk("R8", "end1_o", {159'd0, e1_o}, {159'd0, dir ? 1'b0 : m[1]});
  endtask

  task automatic tick(input logic lp_v);
    lp = lp_v;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run_mode(input logic dual_v, input logic dir_v, input int n,
                          input string tag);
    dual = dual_v;
    dir  = dir_v;
    cur_req = tag;
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e1 = lf[0];
      e2 = lf[3];
      d7 = lf[7];
      tick(1'b1);
      tick(1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    cur_req = "R9";
    compare();
    rst_n = 1'b1;
    tick(1'b0);

    run_mode(1'b0, 1'b1, 170, "R2");

    // strobe held high, held low, rising: no movement
    cur_req = "R1";
    e1 = 1'b1; e2 = 1'b1; d7 = 1'b1;
    for (int i = 0; i < 5; i++) tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 5; i++) begin e1 = ~e1; tick(1'b0); end

    run_mode(1'b0, 1'b0, 170, "R3");
    run_mode(1'b0, 1'b1, 90, "R6");
    run_mode(1'b0, 1'b0, 90, "R6");
    run_mode(1'b1, 1'b1, 100, "R4");
    run_mode(1'b1, 1'b0, 100, "R5");
    run_mode(1'b1, 1'b1, 30, "R4");
    run_mode(1'b0, 1'b0, 40, "R3");

    // reset in mid-run
    cur_req = "R9";
    rst_n = 1'b0;
    tick(1'b1);
    tick(1'b0);
    rst_n = 1'b1;
    tick(1'b0);
    run_mode(1'b0, 1'b1, 20, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule